// File: doc/BRIEF.md
# Twin-Clock Word Store with Selectable Read Latency

This block is a synchronous memory of 4096 nine-bit words with two fully independent access sides, called left and right, each with its own clock. On every rising edge of its clock a side captures an address, write data, an active-low select and a read/not-write flag into input registers. A captured write is committed to the array at that side's next rising edge. A captured read is returned either in the cycle right after capture (flow-through) or one cycle later through an output register (pipelined).

The left side always returns read data through the output register. The right side picks its latency with a static mode pin. Each side has an active-high hold input that freezes its whole register state. It also has an asynchronous active-low output enable. Instead of a tri-state bus it presents read data with a drive flag, and the data is forced to zero whenever the flag is low. When both sides write the same word on one shared edge, the left side's data is kept.

Top module: `twin_clock_store`

## Requirements
- R1: A write captured on either side at edge k is committed at edge k+1, so a read of that address captured on either side at edge k+1 or later returns the new 9-bit word.
- R2: The left side is pipelined: for a read captured at edge k, l_drv goes to 1 and l_rdata carries the word after edge k+1.
- R3: With r_pipe = 0 the right side is flow-through: for a read captured at edge k, r_drv = 1 and r_rdata holds the word after edge k. With r_pipe = 1 the right side behaves as in R2.
- R4: The output cycle that belongs to a captured write has the drive flag at 0. That cycle follows edge k in flow-through mode and edge k+1 in pipelined mode.
- R5: A select of 1 at an edge deselects the side for that cycle, and its output cycle has the drive flag at 0. After a one-cycle deselect, a pipelined side drives again only after the second consecutive edge with select at 0.
- R6: Output enable at 1 forces the drive flag and the data to 0 at once, with no clock edge. Returning it to 0 restores the clocked output state.
- R7: With hold at 1 an edge is ignored by that side: no inputs are captured, no write is committed, and the outputs keep their value. A read captured before the hold still completes after the hold is released.
- R8: If both sides capture a write to the same address at the same edge of a shared clock, the left side's data is the one stored.
- R9: Reset, sampled on each side's rising edge, clears the pending operation and the output register, so the drive flags are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left side clock |
| rst | input | 1 | Synchronous reset, active high, sampled by both clocks |
| l_hold | input | 1 | Left hold: 1 freezes the left registers |
| l_sel_n | input | 1 | Left select, active low |
| l_rd | input | 1 | Left read (1) or write (0) |
| l_oe_n | input | 1 | Left asynchronous output enable, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left read data, zero when not driven |
| l_drv | output | 1 | Left drive flag |
| r_clk | input | 1 | Right side clock |
| r_pipe | input | 1 | Right latency mode: 1 pipelined, 0 flow-through |
| r_hold | input | 1 | Right hold: 1 freezes the right registers |
| r_sel_n | input | 1 | Right select, active low |
| r_rd | input | 1 | Right read (1) or write (0) |
| r_oe_n | input | 1 | Right asynchronous output enable, active low |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right read data, zero when not driven |
| r_drv | output | 1 | Right drive flag |

## Verification
The hardest situation to reach is a same-address write from both sides on one edge, because it only arises when the two clocks share their edges. The bench ties both clocks to one source and presents both writes in the same cycle. It then reads the word back through each side. It also checks a hold that lands while a read sits in the input register, which needs a write request presented during the freeze. Afterwards it observes both that the old read completes and that the frozen write never reached the array.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/tcs_store.sv
module tcs_store #(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          l_clk,
    input  logic          l_we,
    input  logic [AW-1:0] l_waddr,
    input  logic [DW-1:0] l_wdata,
    input  logic [AW-1:0] l_raddr,
    output logic [DW-1:0] l_rword,
    input  logic          r_clk,
    input  logic          r_we,
    input  logic [AW-1:0] r_waddr,
    input  logic [DW-1:0] r_wdata,
    input  logic [AW-1:0] r_raddr,
    output logic [DW-1:0] r_rword
);
    localparam int DEPTH = 1 << AW;

    // One bank per writing side; the tag pair tells which bank holds the newest word.
    logic [DW-1:0]    bank_l [DEPTH];
    logic [DW-1:0]    bank_r [DEPTH];
    logic [DEPTH-1:0] tag_l;
    logic [DEPTH-1:0] tag_r;
    logic             r_blocked;

    // Same-edge collision on one address: the right write yields (R8).
    assign r_blocked = l_we && (l_waddr == r_waddr);

    always_ff @(posedge l_clk) begin
        if (l_we) begin
            bank_l[l_waddr] <= l_wdata;
            tag_l[l_waddr]  <= ~tag_r[l_waddr];
        end
    end

    always_ff @(posedge r_clk) begin
        if (r_we && !r_blocked) begin
            bank_r[r_waddr] <= r_wdata;
            tag_r[r_waddr]  <= tag_l[r_waddr];
        end
    end

    assign l_rword = (tag_l[l_raddr] ^ tag_r[l_raddr]) ? bank_l[l_raddr] : bank_r[l_raddr];
    assign r_rword = (tag_l[r_raddr] ^ tag_r[r_raddr]) ? bank_l[r_raddr] : bank_r[r_raddr];
endmodule

// File: rtl/tcs_side.sv
module tcs_side
    import tcs_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe,
    input  logic          hold,
    input  logic          sel_n,
    input  logic          rd,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] rword,
    output logic [DW-1:0] rdata,
    output logic          drv
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          drv2;
        logic [DW-1:0] q2;
    } side_st_t;

    side_st_t st_d, st_q;
    logic          drv_clk;
    logic [DW-1:0] data_clk;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (sel_n)   st_d.op = OP_IDLE;
            else if (rd) st_d.op = OP_READ;
            else         st_d.op = OP_WRITE;
            st_d.a    = addr;
            st_d.d    = wdata;
            st_d.drv2 = (st_q.op == OP_READ);
            st_d.q2   = (st_q.op == OP_READ) ? rword : '0;
        end
        if (rst) begin
            st_d.op   = OP_IDLE;
            st_d.a    = '0;
            st_d.d    = '0;
            st_d.drv2 = 1'b0;
            st_d.q2   = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // A captured write commits on the next edge this side is not frozen.
    assign we        = (st_q.op == OP_WRITE) && !hold && !rst;
    assign mem_addr  = st_q.a;
    assign mem_wdata = st_q.d;

    assign drv_clk  = pipe ? st_q.drv2 : (st_q.op == OP_READ);
    assign data_clk = pipe ? st_q.q2 : rword;
    assign drv      = drv_clk && !oe_n;
    assign rdata    = drv ? data_clk : '0;

    // R2/R3: a read in the input stage fills the output stage next edge
    p_pipe_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q.op == OP_READ) |=> st_q.drv2);

    // R4: a write in the input stage leaves the output stage silent
    p_write_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q.op == OP_WRITE) |=> !st_q.drv2);

    // R5: a deselected cycle leaves the output stage silent
    p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
        (!hold && st_q.op == OP_IDLE) |=> !st_q.drv2);

    // R7: hold freezes captured address and clocked drive state
    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(st_q.a) && $stable(st_q.op) && $stable(st_q.q2)));

    // R6: a disabled output carries zero data
    p_oe_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (rdata == '0 && !drv));
endmodule

// File: rtl/twin_clock_store.sv
module twin_clock_store #(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          l_clk,
    input  logic          rst,
    input  logic          l_hold,
    input  logic          l_sel_n,
    input  logic          l_rd,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_drv,
    input  logic          r_clk,
    input  logic          r_pipe,
    input  logic          r_hold,
    input  logic          r_sel_n,
    input  logic          r_rd,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_drv
);
    logic          l_we, r_we;
    logic [AW-1:0] l_maddr, r_maddr;
    logic [DW-1:0] l_mwdata, r_mwdata;
    logic [DW-1:0] l_rword, r_rword;

    tcs_side #(.AW(AW), .DW(DW)) u_left (
        .clk(l_clk), .rst(rst), .pipe(1'b1), .hold(l_hold),
        .sel_n(l_sel_n), .rd(l_rd), .oe_n(l_oe_n),
        .addr(l_addr), .wdata(l_wdata),
        .we(l_we), .mem_addr(l_maddr), .mem_wdata(l_mwdata),
        .rword(l_rword), .rdata(l_rdata), .drv(l_drv)
    );

    tcs_side #(.AW(AW), .DW(DW)) u_right (
        .clk(r_clk), .rst(rst), .pipe(r_pipe), .hold(r_hold),
        .sel_n(r_sel_n), .rd(r_rd), .oe_n(r_oe_n),
        .addr(r_addr), .wdata(r_wdata),
        .we(r_we), .mem_addr(r_maddr), .mem_wdata(r_mwdata),
        .rword(r_rword), .rdata(r_rdata), .drv(r_drv)
    );

    tcs_store #(.AW(AW), .DW(DW)) u_store (
        .l_clk(l_clk), .l_we(l_we), .l_waddr(l_maddr), .l_wdata(l_mwdata),
        .l_raddr(l_maddr), .l_rword(l_rword),
        .r_clk(r_clk), .r_we(r_we), .r_waddr(r_maddr), .r_wdata(r_mwdata),
        .r_raddr(r_maddr), .r_rword(r_rword)
    );
endmodule

// File: tb/sim_twin_clock_store.sv
`timescale 1ns/1ps
module sim_twin_clock_store;
    logic clk = 1'b0;
    logic rst;
    logic l_hold, l_sel_n, l_rd, l_oe_n;
    logic [11:0] l_addr;
    logic [8:0]  l_wdata, l_rdata;
    logic l_drv;
    logic r_pipe, r_hold, r_sel_n, r_rd, r_oe_n;
    logic [11:0] r_addr;
    logic [8:0]  r_wdata, r_rdata;
    logic r_drv;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    twin_clock_store u0 (
        .l_clk(clk), .rst(rst), .l_hold(l_hold), .l_sel_n(l_sel_n), .l_rd(l_rd),
        .l_oe_n(l_oe_n), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_drv(l_drv),
        .r_clk(clk), .r_pipe(r_pipe), .r_hold(r_hold), .r_sel_n(r_sel_n),
        .r_rd(r_rd), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_drv(r_drv)
    );

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic setl(bit seln, bit rdf, logic [11:0] a, logic [8:0] d);
        l_sel_n = seln; l_rd = rdf; l_addr = a; l_wdata = d;
    endtask

    task automatic setr(bit seln, bit rdf, logic [11:0] a, logic [8:0] d);
        r_sel_n = seln; r_rd = rdf; r_addr = a; r_wdata = d;
    endtask

    task automatic t_reset();
        rst = 1; l_hold = 0; r_hold = 0; l_oe_n = 0; r_oe_n = 0; r_pipe = 0;
        setl(1, 1, 0, 0); setr(1, 1, 0, 0);
        step(); step();
        chk("R9 left drive in reset", {8'd0, l_drv}, 9'd0);
        chk("R9 right drive in reset", {8'd0, r_drv}, 9'd0);
        rst = 0;
        step();
        chk("R9 left data after reset", l_rdata, 9'd0);
    endtask

    task automatic t_left_pipe();
        setl(0, 0, 12'd5, 9'h1A5); step();
        setl(0, 1, 12'd5, 0);      step();
        chk("R4 left write cycle silent", {8'd0, l_drv}, 9'd0);
        setl(1, 1, 0, 0);          step();
        chk("R2 left drive", {8'd0, l_drv}, 9'd1);
        chk("R2 left data", l_rdata, 9'h1A5);
        step();
        chk("R5 left idle silent", {8'd0, l_drv}, 9'd0);
    endtask

    task automatic t_flow();
        setr(0, 0, 12'd7, 9'h0F3); step();
        chk("R4 right flow write silent", {8'd0, r_drv}, 9'd0);
        setr(0, 1, 12'd7, 0); step();
        chk("R3 flow drive", {8'd0, r_drv}, 9'd1);
        chk("R3 flow data", r_rdata, 9'h0F3);
        setr(0, 1, 12'd5, 0); step();
        chk("R1 right sees left word", r_rdata, 9'h1A5);
        setl(0, 0, 12'd30, 9'h077); setr(1, 1, 0, 0); step();
        setl(1, 1, 0, 0); setr(0, 1, 12'd30, 0); step();
        chk("R1 next-edge cross read", r_rdata, 9'h077);
        setr(1, 1, 0, 0); step();
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 12; i++) begin
            setl(0, 0, 12'((i * 37 + 100) % 4096), 9'((i * 29 + 3) & 9'h1FF));
            step();
        end
        setl(1, 1, 0, 0); step();
        for (int i = 0; i < 12; i++) begin
            setr(0, 1, 12'((i * 37 + 100) % 4096), 0);
            step();
            chk("R1 sweep read", r_rdata, 9'((i * 29 + 3) & 9'h1FF));
        end
        setr(1, 1, 0, 0); step();
    endtask

    task automatic t_right_pipe();
        r_pipe = 1; step(); step();
        setr(0, 1, 12'd7, 0); step();
        chk("R3 pipe first cycle silent", {8'd0, r_drv}, 9'd0);
        setr(1, 1, 0, 0); step();
        chk("R3 pipe drive", {8'd0, r_drv}, 9'd1);
        chk("R3 pipe data", r_rdata, 9'h0F3);
        step();
    endtask

    task automatic t_deselect();
        setl(0, 1, 12'd5, 0); step(); step();
        chk("R2 steady read", {8'd0, l_drv}, 9'd1);
        setl(1, 1, 12'd5, 0); step();
        chk("R5 drive held one cycle", {8'd0, l_drv}, 9'd1);
        setl(0, 1, 12'd5, 0); step();
        chk("R5 first reselect edge silent", {8'd0, l_drv}, 9'd0);
        step();
        chk("R5 second reselect edge drives", {8'd0, l_drv}, 9'd1);
        chk("R5 data back", l_rdata, 9'h1A5);
    endtask

    task automatic t_oe();
        l_oe_n = 1; #1;
        chk("R6 async drive off", {8'd0, l_drv}, 9'd0);
        chk("R6 async data zero", l_rdata, 9'd0);
        step();
        chk("R6 stays off over edge", {8'd0, l_drv}, 9'd0);
        l_oe_n = 0; #1;
        chk("R6 restored drive", {8'd0, l_drv}, 9'd1);
        chk("R6 restored data", l_rdata, 9'h1A5);
    endtask

    task automatic t_hold();
        setl(0, 0, 12'd9, 9'h111); step();
        setl(0, 1, 12'd5, 0); step(); step();
        l_hold = 1; setl(0, 0, 12'd9, 9'h055); step(); step();
        chk("R7 frozen drive", {8'd0, l_drv}, 9'd1);
        chk("R7 frozen data", l_rdata, 9'h1A5);
        l_hold = 0; setl(0, 1, 12'd9, 0); step();
        chk("R7 held read completes", l_rdata, 9'h1A5);
        step();
        chk("R7 frozen write not taken", l_rdata, 9'h111);
        setl(1, 1, 0, 0); step();
    endtask

    task automatic t_collide();
        setl(0, 0, 12'd20, 9'h0AA); setr(0, 0, 12'd20, 9'h155); step();
        setl(1, 1, 0, 0); setr(1, 1, 0, 0); step();
        setl(0, 1, 12'd20, 0); setr(0, 1, 12'd20, 0); step();
        step();
        chk("R8 left reads left data", l_rdata, 9'h0AA);
        chk("R8 right reads left data", r_rdata, 9'h0AA);
    endtask

    task automatic t_reset_mid();
        chk("R9 pre-reset drive", {8'd0, l_drv}, 9'd1);
        rst = 1; step();
        chk("R9 left cleared", {8'd0, l_drv}, 9'd0);
        chk("R9 right cleared", {8'd0, r_drv}, 9'd0);
        rst = 0; setl(1, 1, 0, 0); setr(1, 1, 0, 0); step();
        chk("R9 stays clear", {8'd0, l_drv}, 9'd0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_left_pipe();
        t_flow();
        t_sweep();
        t_right_pipe();
        t_deselect();
        t_oe();
        t_hold();
        t_collide();
        t_reset_mid();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule